// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is the configuration register file of a PC system chipset, reached over an 8-bit I/O bus through an index/data port pair. Software writes a register number to the index port and then reaches that register through one of two data ports. Each data port only reaches its own set of register numbers. Any other access through a data port is dropped on write and reads back a fixed idle value.

Some writes have side effects, which the block drives as outputs:
- a level for the external-cache enable;
- a level for the SMRAM-map enable;
- one-cycle strobes for a wait-state update and a memory-map recalculation;
- a one-cycle SMI request, together with a sticky forced-green power flag.

The power-management status register reads back live state merged with its stored bits. This live state is the in-SMM input and the forced-green flag. The remapping, cache and SMM logic that acts on these outputs sits outside this block.

Top module: `chipset_cfg_port`

## Requirements
- R1: A write to I/O address 0x22 loads the 8-bit index. A read of 0x22 returns the index with read-enable high. Reset clears the index to 0x00.
- R2: Data port 0x23 reaches only index 0x01. At any other index, a write there changes no register and a read returns 0xFF.
- R3: Data port 0x24 reaches only indices 0x20 to 0x2C and 0xE0 to 0xEF. Outside these windows, a write changes no register and a read returns 0xFF. Inside them, a read returns the stored byte, except for index 0xE0 (see R9).
- R4: `cache_en` follows bit 4 of register 0x21. Each write to register 0x21 raises `waitstate_upd` for exactly the one cycle after the write edge.
- R5: A write to register 0x22, 0x23 or 0x26 raises `map_recalc` for exactly the one cycle after the write edge. Writes to other registers leave it low.
- R6: `smram_en` follows bit 7 of register 0x24.
- R7: A write to register 0xE1 with data bit 3 set raises `smi_req` for one cycle and sets `forced_green`, but only while stored register 0xE0 bit 0 is 1. In every other case, a write to 0xE1 leaves both untouched.
- R8: A write to register 0xE0 with data bit 0 clear clears `forced_green`. A write with data bit 0 set leaves the flag unchanged.
- R9: A read of register 0xE0 returns the stored byte ANDed with 0xF6. Bit 3 of the result is set when `in_smm` is low, and bit 0 is the `forced_green` flag. The result uses the value of `in_smm` in the read cycle itself.
- R10: `io_rdata_oe` is high only in a read cycle at 0x22, 0x23 or 0x24. Otherwise `io_rdata` is 0x00. A write to any other address changes nothing.
- R11: After reset, all registers, `forced_green`, `smi_req` and both strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational in the read cycle |
| io_rdata_oe | output | 1 | High when the block drives read data |
| in_smm | input | 1 | CPU is currently in system management mode |
| cache_en | output | 1 | External cache enable |
| waitstate_upd | output | 1 | One-cycle wait-state update strobe |
| map_recalc | output | 1 | One-cycle memory-map recalculation strobe |
| smram_en | output | 1 | SMRAM mapping enable |
| smi_req | output | 1 | One-cycle SMI request |
| forced_green | output | 1 | Forced-green power flag |

## Verification
The read of status register 0xE0 must bring together two things in a single cycle: the forced-green flag and the live in-SMM input. The flag comes from an earlier SMI trigger, and the in-SMM input is not stored at all. The bench fires the SMI trigger through register 0xE1. It then moves the index back to 0xE0 and reads with `in_smm` switched inside the read cycle. Both merged bits must be correct against the stored byte. A second read after the flag is cleared shows that bit 0 falls while the other stored bits stay masked.

// File: rtl/chipset_cfg_port.sv
module chipset_cfg_port #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] LO_PORT  = 16'h0023,
  parameter logic [15:0] HI_PORT  = 16'h0024,
  parameter logic [7:0]  IDLE_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rdata_oe,
  input  logic              in_smm,
  output logic              cache_en,
  output logic              waitstate_upd,
  output logic              map_recalc,
  output logic              smram_en,
  output logic              smi_req,
  output logic              forced_green
);
  localparam int NREG = 256;

  logic [7:0] idx_q;
  logic [7:0] regs_q [NREG];
  logic       ws_q, recalc_q, smi_q, fg_q;

  wire sel_idx = io_addr == IDX_PORT[ADDR_W-1:0];
  wire sel_lo  = io_addr == LO_PORT[ADDR_W-1:0];
  wire sel_hi  = io_addr == HI_PORT[ADDR_W-1:0];

  wire lo_hit = idx_q == 8'h01;
  wire hi_hit = (idx_q >= 8'h20 && idx_q <= 8'h2C) || idx_q[7:4] == 4'hE;

  wire lo_wr = io_wr && sel_lo && lo_hit;
  wire hi_wr = io_wr && sel_hi && hi_hit;

  wire smi_fire = hi_wr && idx_q == 8'hE1 && io_wdata[3] && regs_q[8'hE0][0];
  wire fg_clear = hi_wr && idx_q == 8'hE0 && !io_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      if (io_wr && sel_idx) idx_q <= io_wdata;
      if (lo_wr || hi_wr) regs_q[idx_q] <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      recalc_q <= 1'b0;
      smi_q    <= 1'b0;
      fg_q     <= 1'b0;
    end else begin
      ws_q     <= hi_wr && idx_q == 8'h21;
      recalc_q <= hi_wr && (idx_q == 8'h22 || idx_q == 8'h23 || idx_q == 8'h26);
      smi_q    <= smi_fire;
      if (smi_fire)      fg_q <= 1'b1;
      else if (fg_clear) fg_q <= 1'b0;
    end
  end

  wire [7:0] stat_rd = (regs_q[8'hE0] & 8'hF6) | {4'b0, !in_smm, 2'b0, fg_q};

  always_comb begin
    io_rdata    = 8'h00;
    io_rdata_oe = 1'b0;
    if (io_rd) begin
      if (sel_idx) begin
        io_rdata_oe = 1'b1;
        io_rdata    = idx_q;
      end else if (sel_lo) begin
        io_rdata_oe = 1'b1;
        io_rdata    = lo_hit ? regs_q[idx_q] : IDLE_VAL;
      end else if (sel_hi) begin
        io_rdata_oe = 1'b1;
        if (!hi_hit)              io_rdata = IDLE_VAL;
        else if (idx_q == 8'hE0)  io_rdata = stat_rd;
        else                      io_rdata = regs_q[idx_q];
      end
    end
  end

  assign cache_en      = regs_q[8'h21][4];
  assign smram_en      = regs_q[8'h24][7];
  assign waitstate_upd = ws_q;
  assign map_recalc    = recalc_q;
  assign smi_req       = smi_q;
  assign forced_green  = fg_q;
endmodule

// File: rtl/chipset_cfg_port_chk.sv
module chipset_cfg_port_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] LO_PORT  = 16'h0023,
  parameter logic [15:0] HI_PORT  = 16'h0024,
  parameter logic [7:0]  IDLE_VAL = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rdata_oe,
  input logic              cache_en,
  input logic              waitstate_upd,
  input logic              smram_en,
  input logic              smi_req,
  input logic              forced_green,
  input logic [7:0]        idx_q
);
  // R7
  smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |=> !smi_req);

  // R7
  fg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(forced_green) |-> smi_req);

  // R8
  fg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(forced_green) |-> $past(io_wr && io_addr == HI_PORT[ADDR_W-1:0]
                                  && idx_q == 8'hE0 && !io_wdata[0]));

  // R4
  cache_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cache_en) |-> waitstate_upd);

  // R6
  smram_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smram_en) |-> $past(io_wr && io_addr == HI_PORT[ADDR_W-1:0] && idx_q == 8'h24));

  // R10
  oe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata_oe |-> io_rd && (io_addr == IDX_PORT[ADDR_W-1:0] ||
                              io_addr == LO_PORT[ADDR_W-1:0] ||
                              io_addr == HI_PORT[ADDR_W-1:0]));

  // R2
  lo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == LO_PORT[ADDR_W-1:0] && idx_q != 8'h01) |-> io_rdata == IDLE_VAL);
endmodule

bind chipset_cfg_port chipset_cfg_port_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .LO_PORT(LO_PORT),
  .HI_PORT(HI_PORT), .IDLE_VAL(IDLE_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
  .cache_en(cache_en), .waitstate_upd(waitstate_upd), .smram_en(smram_en),
  .smi_req(smi_req), .forced_green(forced_green), .idx_q(idx_q)
);

// File: tb/tb_chipset_cfg_port.sv
module tb_chipset_cfg_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, in_smm = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rdata_oe, cache_en, waitstate_upd, map_recalc, smram_en, smi_req, forced_green;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipset_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .in_smm(in_smm), .cache_en(cache_en), .waitstate_upd(waitstate_upd),
    .map_recalc(map_recalc), .smram_en(smram_en), .smi_req(smi_req),
    .forced_green(forced_green)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata; oe = io_rdata_oe;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic idle;
    @(posedge clk); #1;
  endtask

  task automatic rd_at(input logic [7:0] idx, input logic [15:0] port, input logic [7:0] exp, input string tag);
    logic [7:0] d; logic oe;
    wr(16'h22, idx);
    rd(port, d, oe);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    rd(16'h22, d, oe);
    chk("R1 reset index", d, 8'h00);
    chk("R11 outputs after reset",
        {2'b0, cache_en, waitstate_upd, map_recalc, smram_en, smi_req, forced_green}, 8'h00);
    rd_at(8'h2C, 16'h24, 8'h00, "R11 reg 2C reset");
    rd_at(8'hE0, 16'h24, 8'h08, "R11 R9 status reg after reset");
  endtask

  task automatic t_index;
    logic [7:0] d; logic oe;
    wr(16'h22, 8'h5A);
    rd(16'h22, d, oe);
    chk("R1 index readback", d, 8'h5A);
    chk("R1 index oe", {7'b0, oe}, 8'h01);
  endtask

  task automatic t_lo_port;
    wr(16'h22, 8'h01); wr(16'h23, 8'hC3);
    rd_at(8'h01, 16'h23, 8'hC3, "R2 reg 01 via 23");
    wr(16'h22, 8'h02); wr(16'h23, 8'h77);
    rd_at(8'h02, 16'h23, 8'hFF, "R2 idle at idx 02");
    rd_at(8'h01, 16'h23, 8'hC3, "R2 reg 01 untouched");
    rd_at(8'h20, 16'h23, 8'hFF, "R2 idx 20 via 23 idle");
    rd_at(8'h01, 16'h24, 8'hFF, "R3 idx 01 via 24 idle");
    wr(16'h24, 8'h11);
    rd_at(8'h01, 16'h23, 8'hC3, "R3 write idx 01 via 24 ignored");
  endtask

  task automatic t_hi_window;
    wr(16'h22, 8'h20); wr(16'h24, 8'hA1);
    rd_at(8'h20, 16'h24, 8'hA1, "R3 reg 20");
    wr(16'h22, 8'h2C); wr(16'h24, 8'h5C);
    rd_at(8'h2C, 16'h24, 8'h5C, "R3 reg 2C");
    wr(16'h22, 8'h2D); wr(16'h24, 8'h99);
    rd_at(8'h2D, 16'h24, 8'hFF, "R3 idx 2D idle");
    rd_at(8'h1F, 16'h24, 8'hFF, "R3 idx 1F idle");
    wr(16'h22, 8'hEF); wr(16'h24, 8'h3E);
    rd_at(8'hEF, 16'h24, 8'h3E, "R3 reg EF");
    rd_at(8'hF0, 16'h24, 8'hFF, "R3 idx F0 idle");
    wr(16'h22, 8'h20); wr(16'h23, 8'h00);
    rd_at(8'h20, 16'h24, 8'hA1, "R2 write idx 20 via 23 ignored");
  endtask

  task automatic t_cache;
    wr(16'h22, 8'h21); wr(16'h24, 8'h10);
    chk("R4 cache_en set", {7'b0, cache_en}, 8'h01);
    chk("R4 ws strobe", {7'b0, waitstate_upd}, 8'h01);
    idle;
    chk("R4 ws strobe one cycle", {7'b0, waitstate_upd}, 8'h00);
    wr(16'h24, 8'hEF);
    chk("R4 cache_en clear", {7'b0, cache_en}, 8'h00);
    chk("R4 ws strobe again", {7'b0, waitstate_upd}, 8'h01);
  endtask

  task automatic t_recalc;
    logic [7:0] ids [3] = '{8'h22, 8'h23, 8'h26};
    foreach (ids[k]) begin
      wr(16'h22, ids[k]); wr(16'h24, 8'h00);
      chk($sformatf("R5 recalc idx %02h", ids[k]), {7'b0, map_recalc}, 8'h01);
      idle;
      chk("R5 recalc one cycle", {7'b0, map_recalc}, 8'h00);
    end
    wr(16'h22, 8'h25); wr(16'h24, 8'h00);
    chk("R5 no recalc idx 25", {7'b0, map_recalc}, 8'h00);
  endtask

  task automatic t_smram;
    wr(16'h22, 8'h24); wr(16'h24, 8'h80);
    chk("R6 smram set", {7'b0, smram_en}, 8'h01);
    wr(16'h24, 8'h7F);
    chk("R6 smram clear", {7'b0, smram_en}, 8'h00);
  endtask

  task automatic t_smi;
    wr(16'h22, 8'hE0); wr(16'h24, 8'h00);
    wr(16'h22, 8'hE1); wr(16'h24, 8'h08);
    chk("R7 no smi when E0.0 clear", {6'b0, smi_req, forced_green}, 8'h00);
    wr(16'h22, 8'hE0); wr(16'h24, 8'h01);
    wr(16'h22, 8'hE1); wr(16'h24, 8'h08);
    chk("R7 smi and green", {6'b0, smi_req, forced_green}, 8'h03);
    idle;
    chk("R7 smi single cycle", {6'b0, smi_req, forced_green}, 8'h01);
    wr(16'h24, 8'hF7);
    chk("R7 no smi without bit3", {7'b0, smi_req}, 8'h00);
  endtask

  task automatic t_green_clear;
    wr(16'h22, 8'hE0); wr(16'h24, 8'h03);
    chk("R8 bit0 set keeps green", {7'b0, forced_green}, 8'h01);
    wr(16'h24, 8'h02);
    chk("R8 bit0 clear drops green", {7'b0, forced_green}, 8'h00);
  endtask

  task automatic t_status_merge;
    logic [7:0] d; logic oe;
    wr(16'h22, 8'hE0); wr(16'h24, 8'hFF);
    rd(16'h24, d, oe);
    chk("R9 merge not smm", d, 8'hFE);
    in_smm = 1'b1;
    rd(16'h24, d, oe);
    chk("R9 merge in smm", d, 8'hF6);
    in_smm = 1'b0;
    wr(16'h22, 8'hE1); wr(16'h24, 8'h08);
    wr(16'h22, 8'hE0);
    @(negedge clk);
    io_addr = 16'h24; io_rd = 1'b1; in_smm = 1'b1;
    #1 chk("R9 green and smm same cycle", io_rdata, 8'hF7);
    #1 in_smm = 1'b0;
    #1 chk("R9 green and live smm drop", io_rdata, 8'hFF);
    @(posedge clk); #1 io_rd = 1'b0;
    wr(16'h24, 8'h00);
    rd(16'h24, d, oe);
    chk("R9 after green clear", d, 8'h08);
  endtask

  task automatic t_bus;
    logic [7:0] d; logic oe;
    wr(16'h22, 8'h2A);
    rd(16'h25, d, oe);
    chk("R10 no oe at 25", {oe, d[6:0]}, 8'h00);
    chk("R10 rdata zero at 25", d, 8'h00);
    rd(16'h21, d, oe);
    chk("R10 no oe at 21", {7'b0, oe}, 8'h00);
    wr(16'h25, 8'h33);
    rd(16'h22, d, oe);
    chk("R10 write at 25 ignored", d, 8'h2A);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_index;
    t_lo_port;
    t_hi_window;
    t_cache;
    t_recalc;
    t_smram;
    t_smi;
    t_green_clear;
    t_status_merge;
    t_bus;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule